// File: doc/BRIEF.md
# GPIO Direction and Level Register Block

A memory-mapped register block for 90 general-purpose pins. Software sets each pin's direction and output value through a simple register port: a write strobe, a byte address and write data, with combinational read data. The block drives per-pin output enables and output values to the pads. It returns each pin's level through three read-only registers.

Pins are grouped into banks of 32. The level of an input pin passes through a two-stage synchronizer and then a capture register. For an output pin, the level register shows the value being driven. For the four highest pins the direction bit has the opposite sense. As a result, the all-zero reset state makes those four pins outputs and every other pin an input.

Top module: `gpio_regs`

## Requirements
- R1: Level registers sit at byte offsets 0x00, 0x04 and 0x08 and hold pins 0–31, 32–63 and 64–89. Pin p appears at bit p mod 32 of bank p div 32. Direction registers use the same layout at 0x0C/0x10/0x14, and output-data registers at 0x18/0x1C/0x20.
- R2: For pins 0–85, a direction bit of 1 raises `pin_oe_o` for that pin, and a bit of 0 leaves it low (input).
- R3: For pins 86–89 (bits 22–25 of the register at 0x14), a direction bit of 1 makes the pin an input (`pin_oe_o` low), and a bit of 0 makes it an output.
- R4: While `rst_ni` is low, and right after it rises, every register reads 0. `pin_oe_o` is low for pins 0–85 and high for pins 86–89, and `pin_o` is all zero.
- R5: Bits 31:26 of the third bank (offsets 0x08, 0x14, 0x20) always read 0, whatever was written.
- R6: For an input pin, a change on `pin_i` becomes readable in the level register after the third rising clock edge following the change, and not before.
- R7: For an output pin, the level bit shows the driven output value. After the output-data write edge, the new value is readable after the next rising edge, whatever `pin_i` carries.
- R8: Writes to the level offsets 0x00–0x08 have no effect on any register, on `pin_o` or on `pin_oe_o`.
- R9: Offsets at 0x24 and above, and any address whose two low bits are non-zero, read as 0 and ignore writes.
- R10: Direction and output-data registers read back what was written. `pin_o` and `pin_oe_o` take the new values right after the write edge, and `pin_o` follows the output-data register whatever the direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Single-cycle write strobe |
| addr_i | input | 8 | Byte address within the block |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| pin_i | input | 90 | Pad input levels (asynchronous) |
| pin_o | output | 90 | Pad output values |
| pin_oe_o | output | 90 | Pad output enables, 1 = drive |

## Verification
The bench goes after the polarity boundary between pins 85 and 86. A design that applies one polarity everywhere would let pin 85 drive or disable pin 89. It times the input path edge by edge, so a missing or extra synchronizer stage shows up as a level arriving one cycle early or late. It also drives an output pin whose pad input disagrees with the driven value: a design that always samples the pad would report the wrong level. Writes to the reserved top bits, to the read-only level offsets and to misaligned or unmapped addresses would, in a faulty design, leak into readback or into the pad controls.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  typedef enum logic [1:0] {
    KIND_LVL,
    KIND_DIR,
    KIND_OUT,
    KIND_NONE
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [7:0] bank;
  } reg_sel_t;

  // Word index -> register kind and bank; three groups of nbank words each.
  function automatic reg_sel_t decode_word(input int unsigned word, input int unsigned nbank);
    reg_sel_t s;
    s.kind = KIND_NONE;
    s.bank = '0;
    if (word < nbank) begin
      s.kind = KIND_LVL;
      s.bank = 8'(word);
    end else if (word < 2 * nbank) begin
      s.kind = KIND_DIR;
      s.bank = 8'(word - nbank);
    end else if (word < 3 * nbank) begin
      s.kind = KIND_OUT;
      s.bank = 8'(word - 2 * nbank);
    end
    return s;
  endfunction

  function automatic int unsigned bank_width(input int unsigned num_pins,
                                             input int unsigned data_w,
                                             input int unsigned bank);
    int unsigned rem;
    rem = num_pins - bank * data_w;
    return (rem > data_w) ? data_w : rem;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned BW          = 32,
  parameter int unsigned BASE        = 0,
  parameter int unsigned INV_LO      = 86,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dir_we_i,
  input  logic              out_we_i,
  input  logic [BW-1:0]     wdata_i,
  input  logic [BW-1:0]     pin_i,
  output logic [BW-1:0]     pin_o,
  output logic [BW-1:0]     oe_o,
  output logic [DATA_W-1:0] rd_dir_o,
  output logic [DATA_W-1:0] rd_out_o,
  output logic [DATA_W-1:0] rd_lvl_o
);

  logic [BW-1:0] dir_q, out_q, lvl_q, sync_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      out_q <= '0;
    end else begin
      if (dir_we_i) dir_q <= wdata_i;
      if (out_we_i) out_q <= wdata_i;
    end
  end

  gpio_sync #(
    .WIDTH (BW),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (sync_w)
  );

  // Pins at or above INV_LO use inverted direction sense.
  for (genvar i = 0; i < BW; i++) begin : g_oe
    if (BASE + i >= INV_LO) begin : g_inv
      assign oe_o[i] = ~dir_q[i];
    end else begin : g_norm
      assign oe_o[i] = dir_q[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= (oe_o & out_q) | (~oe_o & sync_w);
  end

  assign pin_o    = out_q;
  assign rd_dir_o = DATA_W'(dir_q);
  assign rd_out_o = DATA_W'(out_q);
  assign rd_lvl_o = DATA_W'(lvl_q);

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 90,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned INV_LO      = 86,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o
);

  localparam int unsigned NBANK = (NUM_PINS + DATA_W - 1) / DATA_W;

  logic [DATA_W-1:0] rd_lvl [NBANK];
  logic [DATA_W-1:0] rd_dir [NBANK];
  logic [DATA_W-1:0] rd_out [NBANK];
  reg_sel_t          sel;

  always_comb begin
    if (addr_i[1:0] == 2'b00) sel = decode_word(32'(addr_i[ADDR_W-1:2]), NBANK);
    else                      sel = '{kind: KIND_NONE, bank: '0};
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam int unsigned BASE = b * DATA_W;
    localparam int unsigned BW   = bank_width(NUM_PINS, DATA_W, b);

    gpio_bank #(
      .DATA_W     (DATA_W),
      .BW         (BW),
      .BASE       (BASE),
      .INV_LO     (INV_LO),
      .SYNC_STAGES(SYNC_STAGES)
    ) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .dir_we_i(wr_en_i && sel.kind == KIND_DIR && sel.bank == 8'(b)),
      .out_we_i(wr_en_i && sel.kind == KIND_OUT && sel.bank == 8'(b)),
      .wdata_i (wdata_i[BW-1:0]),
      .pin_i   (pin_i[BASE +: BW]),
      .pin_o   (pin_o[BASE +: BW]),
      .oe_o    (pin_oe_o[BASE +: BW]),
      .rd_dir_o(rd_dir[b]),
      .rd_out_o(rd_out[b]),
      .rd_lvl_o(rd_lvl[b])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (sel.bank == 8'(b)) begin
        case (sel.kind)
          KIND_LVL: rdata_o = rd_lvl[b];
          KIND_DIR: rdata_o = rd_dir[b];
          KIND_OUT: rdata_o = rd_out[b];
          default:  rdata_o = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/gpio_regs_chk.sv
module gpio_regs_chk
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_PINS = 90,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned INV_LO   = 86
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_en_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [DATA_W-1:0]   wdata_i,
  input logic [DATA_W-1:0]   rdata_o,
  input logic [NUM_PINS-1:0] pin_o,
  input logic [NUM_PINS-1:0] pin_oe_o
);

  localparam int unsigned NBANK  = (NUM_PINS + DATA_W - 1) / DATA_W;
  localparam int unsigned LAST_W = bank_width(NUM_PINS, DATA_W, NBANK - 1);
  localparam int unsigned TOPBIT = LAST_W - 1;
  localparam logic [ADDR_W-1:0] LVL_END = ADDR_W'(NBANK * 4);
  localparam logic [ADDR_W-1:0] LVL_L   = ADDR_W'((NBANK - 1) * 4);
  localparam logic [ADDR_W-1:0] DIR_0   = ADDR_W'(NBANK * 4);
  localparam logic [ADDR_W-1:0] DIR_L   = ADDR_W'((2 * NBANK - 1) * 4);
  localparam logic [ADDR_W-1:0] OUT_L   = ADDR_W'((3 * NBANK - 1) * 4);
  localparam logic [DATA_W-1:0] RSV     = {DATA_W{1'b1}} << LAST_W;

  function automatic logic [NUM_PINS-1:0] reset_oe();
    logic [NUM_PINS-1:0] v;
    for (int i = 0; i < NUM_PINS; i++) v[i] = (i >= INV_LO);
    return v;
  endfunction
  localparam logic [NUM_PINS-1:0] RST_OE = reset_oe();

  logic lvl_hit;
  assign lvl_hit = (addr_i[1:0] == 2'b00) && (addr_i < LVL_END);

  assert_oe_polarity_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == DIR_0 && wdata_i[0] |=> pin_oe_o[0]);

  assert_inverted_dir_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == DIR_L && wdata_i[TOPBIT] |=> !pin_oe_o[NUM_PINS-1]);

  assert_reset_oe_R4: assert property (@(posedge clk_i)
    !rst_ni |-> pin_oe_o == RST_OE && pin_o == '0);

  assert_reserved_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == LVL_L || addr_i == DIR_L || addr_i == OUT_L) |-> (rdata_o & RSV) == '0);

  assert_lvl_write_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && lvl_hit |=> $stable(pin_oe_o) && $stable(pin_o));

endmodule

bind gpio_regs gpio_regs_chk #(
  .NUM_PINS(NUM_PINS),
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W),
  .INV_LO  (INV_LO)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .pin_o   (pin_o),
  .pin_oe_o(pin_oe_o)
);

// File: tb/sim_gpio_regs.sv
`timescale 1ns/100ps
module sim_gpio_regs;

  localparam int NP = 90;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b1;
  logic          wr_en_i = 1'b0;
  logic [7:0]    addr_i = '0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic [NP-1:0] pin_i = '0;
  logic [NP-1:0] pin_o, pin_oe_o;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #2.5 clk_i = ~clk_i;

  gpio_regs u0 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .pin_i   (pin_i),
    .pin_o   (pin_o),
    .pin_oe_o(pin_oe_o)
  );

  typedef struct packed {
    logic [1:0]  tag;   // 0: R10, 1: R5, 2: R9
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] expv;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{2'd0, 8'h0C, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    '{2'd0, 8'h10, 32'hA5A5_A5A5, 32'hA5A5_A5A5},
    '{2'd1, 8'h14, 32'hFFFF_FFFF, 32'h03FF_FFFF},
    '{2'd0, 8'h18, 32'h1234_5678, 32'h1234_5678},
    '{2'd0, 8'h1C, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    '{2'd1, 8'h20, 32'hFFFF_FFFF, 32'h03FF_FFFF},
    '{2'd0, 8'h0C, 32'h0000_0000, 32'h0000_0000},
    '{2'd0, 8'h14, 32'h0000_0000, 32'h0000_0000},
    '{2'd2, 8'h24, 32'hFFFF_FFFF, 32'h0000_0000},
    '{2'd2, 8'h30, 32'h5555_5555, 32'h0000_0000}
  };

  function automatic string tag_name(input logic [1:0] t);
    case (t)
      2'd1:    return "R5";
      2'd2:    return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [127:0] got, input logic [127:0] expv);
    n_chk++;
    if (got !== expv) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, expv);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1;
    addr_i  = a;
    wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr_i = a;
    #0.2;
    d = rdata_o;
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  logic [NP-1:0] rst_oe_exp;
  always_comb for (int i = 0; i < NP; i++) rst_oe_exp[i] = (i >= 86);

  initial begin
    logic [31:0]   d;
    logic [NP-1:0] oe_snap, po_snap;
    logic [31:0]   dir0_snap;

    // Reset with all pins high: levels must still read zero (R4)
    pin_i = '1;
    #1 rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check("R4 oe during reset", 128'(pin_oe_o), 128'(rst_oe_exp));
    rst_ni = 1'b1;
    for (int k = 0; k < 9; k++) begin
      rd(8'(k * 4), d);
      check("R4 reg after reset", 128'(d), 128'h0);
    end
    check("R4 oe after reset", 128'(pin_oe_o), 128'(rst_oe_exp));
    check("R4 pin_o after reset", 128'(pin_o), 128'h0);
    pin_i = '0;
    repeat (4) step();

    // Vector table: write then read back
    for (int v = 0; v < 10; v++) begin
      wr(VECS[v].addr, VECS[v].wdata);
      rd(VECS[v].addr, d);
      check(tag_name(VECS[v].tag), 128'(d), 128'(VECS[v].expv));
    end
    check("R10 pin_o follows out regs", 128'(pin_o),
          128'({26'h3FF_FFFF, 32'hDEAD_BEEF, 32'h1234_5678}));
    wr(8'h18, 32'h0); wr(8'h1C, 32'h0); wr(8'h20, 32'h0); wr(8'h10, 32'h0);

    // Direction polarity across the 85/86 boundary (R1, R2, R3)
    wr(8'h0C, 32'h0000_0001);
    wr(8'h14, 32'h0200_0001);
    check("R2 pin0 output", 128'(pin_oe_o[0]), 128'h1);
    check("R2 pin1 input", 128'(pin_oe_o[1]), 128'h0);
    check("R1 R2 pin64 output", 128'(pin_oe_o[64]), 128'h1);
    check("R2 pin85 input", 128'(pin_oe_o[85]), 128'h0);
    check("R3 pin89 input", 128'(pin_oe_o[89]), 128'h0);
    check("R3 pin86..88 output", 128'(pin_oe_o[88:86]), 128'h7);
    wr(8'h14, 32'h0);

    // Input synchronizer latency (R6, R1)
    pin_i[5]  = 1'b1;
    pin_i[40] = 1'b1;
    step();
    rd(8'h00, d); check("R6 edge1 pin5", 128'(d[5]), 128'h0);
    step();
    rd(8'h00, d); check("R6 edge2 pin5", 128'(d[5]), 128'h0);
    step();
    rd(8'h00, d); check("R6 edge3 pin5", 128'(d[5]), 128'h1);
    rd(8'h04, d); check("R1 R6 pin40 in bank1 bit8", 128'(d), 128'h100);

    // Output pin level shows driven value, not pad input (R7)
    wr(8'h18, 32'h0000_0001);
    check("R10 pin_o0", 128'(pin_o[0]), 128'h1);
    rd(8'h00, d); check("R7 level before capture", 128'(d[0]), 128'h0);
    step();
    rd(8'h00, d); check("R7 level pin0 driven", 128'(d[0]), 128'h1);

    // Inverted pin 86 as output (dir bit 0), pad input low (R3, R7)
    wr(8'h20, 32'h0040_0000);
    step();
    rd(8'h08, d); check("R3 R7 pin86 level driven", 128'(d[22]), 128'h1);
    // Pin 87 as input (dir bit 1) sees pad, not output data
    wr(8'h14, 32'h0080_0000);
    pin_i[87] = 1'b1;
    repeat (3) step();
    rd(8'h08, d); check("R3 R6 pin87 input level", 128'(d[23]), 128'h1);

    // Level writes ignored (R8)
    oe_snap = pin_oe_o;
    po_snap = pin_o;
    rd(8'h0C, dir0_snap);
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h08, 32'hFFFF_FFFF);
    check("R8 oe unchanged", 128'(pin_oe_o), 128'(oe_snap));
    check("R8 pin_o unchanged", 128'(pin_o), 128'(po_snap));
    rd(8'h0C, d); check("R8 dir0 unchanged", 128'(d), 128'(dir0_snap));
    rd(8'h04, d); check("R8 level1 unchanged", 128'(d), 128'h100);

    // Misaligned and unmapped accesses (R9)
    wr(8'h0D, 32'hFFFF_FFFF);
    wr(8'h1A, 32'hFFFF_FFFF);
    rd(8'h0C, d); check("R9 misaligned dir write ignored", 128'(d), 128'(dir0_snap));
    rd(8'h0D, d); check("R9 misaligned read zero", 128'(d), 128'h0);
    check("R9 oe unchanged", 128'(pin_oe_o), 128'(oe_snap));
    check("R9 pin_o unchanged", 128'(pin_o), 128'(po_snap));
    rd(8'hFC, d); check("R9 top offset zero", 128'(d), 128'h0);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule